// File: doc/BRIEF.md
# Block Check Accumulator with Deferred Exclusion

This block keeps a running block check over the characters of a received message. Each received byte arrives with a one-cycle strobe. The block folds the byte into either a 16-bit cyclic redundancy check or an 8-bit longitudinal XOR sum. Software or the receive framer sometimes decides only after a byte has landed that the byte must not count toward the check, for example a sync or a leading escape character. To allow for this, the block holds two values one character apart: the current accumulation, and the accumulation as it stood before the most recent byte. A drop request restores the current value from the older copy. If no drop request arrives, the byte stays in the check.

A synchronous clear starts a new message. It loads a preset of all zeros or all ones into both values. The preset selects odd or even sum in sum mode and the CRC seed in CRC mode. The transmitter sends the CRC non-inverted, so a receiver that accumulates the whole block including the check bytes sees a zero residual, and `chk_ok` reports this. When transparent reception is flagged, the CRC is used whatever mode is selected.

Top module: `bcs_accum`

## Requirements
- R1: While reset is high at a clock edge, the current and held values become 0x0000. After reset `chk_value` is 0x0000 and `chk_ok` is 1.
- R2: `clear` loads 0xFFFF (`preset_ones`=1) or 0x0000 (`preset_ones`=0) into both the current and the held value. It takes priority over a byte strobe and over a drop request in the same cycle.
- R3: In CRC mode each byte is shifted in least significant bit first through the reflected form (0xA001) of the polynomial x^16 + x^15 + x^2 + 1. The ASCII string "123456789" gives 0xBB3D from a zero preset and 0x4B37 from an all-ones preset.
- R4: In CRC mode, appending the resulting CRC low byte first and then the high byte leaves a residual of 0x0000, and `chk_ok` is 1.
- R5: Sum mode applies when `mode_sel`=2'b11 and `transparent`=0. Each byte is XORed into bits 7:0, and bits 15:8 keep their preset. In sum mode `chk_ok` is 1 exactly when bits 7:0 are zero.
- R6: With `transparent`=1 the block computes the CRC even when `mode_sel`=2'b11.
- R7: The reserved `mode_sel` values 2'b00 and 2'b10 behave the same as 2'b01 (CRC).
- R8: A drop request without a byte strobe sets the current value equal to the held value. A second drop request before the next byte changes nothing.
- R9: A drop request together with a byte strobe removes the previous byte and folds the new byte into the held value. The held value stays unchanged.
- R10: With no strobe, drop request or clear, both values hold.
- R11: A strobe, drop request or clear at one clock edge is visible on `chk_value` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Start of message: load the preset into both values |
| preset_ones | input | 1 | Preset select: 1 loads all ones, 0 loads all zeros |
| mode_sel | input | 2 | 2'b11 selects the XOR sum; any other value selects the CRC |
| transparent | input | 1 | Forces the CRC when 1 |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| drop_last | input | 1 | Exclude the most recently accumulated byte |
| chk_value | output | 16 | Current check value |
| chk_ok | output | 1 | Check residual is zero for the active algorithm |

## Verification
Every input event lands in a register at the next rising edge, so `chk_value` takes its new value one cycle after the strobe. `chk_ok` follows combinationally from that register and the mode inputs. The bench changes inputs on the falling edge, holds each event for one rising edge, and removes it at the next falling edge. It samples outputs at that same falling edge, half a cycle after the edge that took the event. Expected values come from published CRC check constants and from hand-computed XOR sums, not from a model of the datapath.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
    localparam int BYTE_W = 8;
    localparam int CHK_W  = 16;
    // Reflected form of x^16 + x^15 + x^2 + 1
    localparam logic [CHK_W-1:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [1:0] {
        MODE_RSV_A = 2'b00,
        MODE_CRC   = 2'b01,
        MODE_RSV_B = 2'b10,
        MODE_SUM   = 2'b11
    } mode_sel_e;

    typedef enum logic {
        ALG_CRC = 1'b0,
        ALG_SUM = 1'b1
    } alg_e;

    typedef struct packed {
        logic              valid;
        logic              drop;
        logic [BYTE_W-1:0] data;
    } rx_evt_t;

    function automatic alg_e pick_alg(input mode_sel_e m, input logic transp);
        return (!transp && m == MODE_SUM) ? ALG_SUM : ALG_CRC;
    endfunction

    function automatic logic [CHK_W-1:0] preset_word(input logic ones);
        return ones ? {CHK_W{1'b1}} : {CHK_W{1'b0}};
    endfunction
endpackage

// File: rtl/bcs_step.sv
`timescale 1ns/1ps
module bcs_step
    import bcs_pkg::*;
#(
    parameter int              SW     = CHK_W,
    parameter int              DW     = BYTE_W,
    parameter logic [SW-1:0]   POLY   = CRC_POLY_REFL
) (
    input  logic [SW-1:0] seed,
    input  logic [DW-1:0] data,
    input  alg_e          alg,
    output logic [SW-1:0] next
);
    localparam int UPPER_W = SW - DW;

    logic [SW-1:0] chain [0:DW];
    logic [SW-1:0] sum_next;

    assign chain[0] = seed;

    generate
        for (genvar b = 0; b < DW; b++) begin : g_bit
            logic fb;
            assign fb          = chain[b][0] ^ data[b];
            assign chain[b+1]  = (chain[b] >> 1) ^ (fb ? POLY : {SW{1'b0}});
        end
    endgenerate

    generate
        if (UPPER_W > 0) begin : g_sum_wide
            assign sum_next = {seed[SW-1:DW], seed[DW-1:0] ^ data};
        end else begin : g_sum_narrow
            assign sum_next = seed ^ data[SW-1:0];
        end
    endgenerate

    assign next = (alg == ALG_SUM) ? sum_next : chain[DW];
endmodule

// File: rtl/bcs_hold.sv
`timescale 1ns/1ps
module bcs_hold
    import bcs_pkg::*;
#(
    parameter int SW = CHK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [SW-1:0] preset,
    input  logic          valid,
    input  logic          drop,
    input  logic [SW-1:0] stepped,
    output logic [SW-1:0] cur_q,
    output logic [SW-1:0] held_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            held_q <= '0;
        end else if (clear) begin
            cur_q  <= preset;
            held_q <= preset;
        end else if (valid) begin
            cur_q <= stepped;
            if (!drop) held_q <= cur_q;
        end else if (drop) begin
            cur_q <= held_q;
        end
    end

    // R2
    clear_loads_both_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cur_q == held_q) && (cur_q == $past(preset)));

    // R8
    drop_restores_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && !valid && !clear) |=> (cur_q == $past(held_q)) && $stable(held_q));

    // R9
    drop_with_byte_keeps_held_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && valid && !clear) |=> $stable(held_q));

    // R3
    byte_shifts_held_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !drop && !clear) |=> (held_q == $past(cur_q)));

    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !drop && !clear) |=> ($stable(cur_q) && $stable(held_q)));
endmodule

// File: rtl/bcs_accum.sv
`timescale 1ns/1ps
module bcs_accum
    import bcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        preset_ones,
    input  logic [1:0]  mode_sel,
    input  logic        transparent,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        drop_last,
    output logic [15:0] chk_value,
    output logic        chk_ok
);
    alg_e            alg;
    rx_evt_t         evt;
    logic [CHK_W-1:0] cur_q;
    logic [CHK_W-1:0] held_q;
    logic [CHK_W-1:0] seed;
    logic [CHK_W-1:0] stepped;

    assign alg = pick_alg(mode_sel_e'(mode_sel), transparent);
    assign evt = '{valid: byte_valid, drop: drop_last, data: byte_data};

    // A drop in the same cycle as a byte folds the new byte onto the older copy
    assign seed = evt.drop ? held_q : cur_q;

    bcs_step #(.SW(CHK_W), .DW(BYTE_W), .POLY(CRC_POLY_REFL)) u_step (
        .seed (seed),
        .data (evt.data),
        .alg  (alg),
        .next (stepped)
    );

    bcs_hold #(.SW(CHK_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .preset  (preset_word(preset_ones)),
        .valid   (evt.valid),
        .drop    (evt.drop),
        .stepped (stepped),
        .cur_q   (cur_q),
        .held_q  (held_q)
    );

    assign chk_value = cur_q;
    assign chk_ok    = (alg == ALG_SUM) ? (cur_q[BYTE_W-1:0] == '0) : (cur_q == '0);

    // R5
    sum_upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !drop_last && !clear && alg == ALG_SUM) |=>
            (chk_value[15:8] == $past(chk_value[15:8])));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (chk_value == 16'h0000));
endmodule

// File: tb/bcs_accum_tb.sv
`timescale 1ns/1ps
module bcs_accum_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        clear;
    logic        preset_ones;
    logic [1:0]  mode_sel;
    logic        transparent;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        drop_last;
    logic [15:0] chk_value;
    logic        chk_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bcs_accum u_dut (
        .clk(clk), .rst(rst), .clear(clear), .preset_ones(preset_ones),
        .mode_sel(mode_sel), .transparent(transparent), .byte_valid(byte_valid),
        .byte_data(byte_data), .drop_last(drop_last),
        .chk_value(chk_value), .chk_ok(chk_ok)
    );

    // {valid, drop, data, expected value, expected ok}: even sum from zero preset
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h12, 16'h0012, 1'b0},
        {1'b1, 1'b0, 8'h34, 16'h0026, 1'b0},
        {1'b0, 1'b1, 8'h00, 16'h0012, 1'b0},
        {1'b1, 1'b0, 8'h0F, 16'h001D, 1'b0},
        {1'b1, 1'b1, 8'hF0, 16'h00E2, 1'b0},
        {1'b1, 1'b0, 8'hE2, 16'h0000, 1'b1},
        {1'b0, 1'b1, 8'h00, 16'h00E2, 1'b0},
        {1'b0, 1'b1, 8'h00, 16'h00E2, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic d, input logic [7:0] b);
        @(negedge clk);
        byte_valid = v; drop_last = d; byte_data = b;
        @(negedge clk);
        byte_valid = 1'b0; drop_last = 1'b0; byte_data = 8'h00;
    endtask

    task automatic do_clear(input logic ones);
        @(negedge clk);
        clear = 1'b1; preset_ones = ones;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic feed_digits(input int first);
        for (int i = first; i < 9; i++) step(1'b1, 1'b0, 8'h31 + 8'(i));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clear = 1'b0; preset_ones = 1'b0; mode_sel = 2'b01;
        transparent = 1'b0; byte_valid = 1'b0; byte_data = 8'h00; drop_last = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 reset value", chk_value, 16'h0000);
        check("R1 reset ok", {15'b0, chk_ok}, 16'h0001);

        // R5 R8 R9 table in sum mode
        mode_sel = 2'b11;
        do_clear(1'b0);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][26], VEC[i][25], VEC[i][24:17]);
            check("R5/R8/R9 table value", chk_value, VEC[i][16:1]);
            check("R5 table ok", {15'b0, chk_ok}, {15'b0, VEC[i][0]});
        end

        // R5 odd sum: upper byte keeps ones preset
        do_clear(1'b1);
        check("R2 clear ones", chk_value, 16'hFFFF);
        step(1'b1, 1'b0, 8'h0F);
        check("R5 odd sum", chk_value, 16'hFFF0);
        step(1'b1, 1'b0, 8'hF0);
        check("R5 odd sum ok value", chk_value, 16'hFF00);
        check("R5 odd sum ok", {15'b0, chk_ok}, 16'h0001);

        // R3 CRC from zero preset
        mode_sel = 2'b01;
        do_clear(1'b0);
        feed_digits(0);
        check("R3 crc zero preset", chk_value, 16'hBB3D);
        // R4 residual
        step(1'b1, 1'b0, 8'h3D);
        step(1'b1, 1'b0, 8'hBB);
        check("R4 residual", chk_value, 16'h0000);
        check("R4 ok", {15'b0, chk_ok}, 16'h0001);

        // R3 CRC from ones preset, then residual R4
        do_clear(1'b1);
        feed_digits(0);
        check("R3 crc ones preset", chk_value, 16'h4B37);
        step(1'b1, 1'b0, 8'h37);
        step(1'b1, 1'b0, 8'h4B);
        check("R4 residual ones", chk_value, 16'h0000);

        // R8 drop in CRC mode
        do_clear(1'b0);
        step(1'b1, 1'b0, 8'h31);
        step(1'b1, 1'b0, 8'h58);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        feed_digits(1);
        check("R8 drop excludes byte", chk_value, 16'hBB3D);

        // R9 drop together with next byte
        do_clear(1'b0);
        step(1'b1, 1'b0, 8'h31);
        step(1'b1, 1'b0, 8'h5A);
        step(1'b1, 1'b1, 8'h32);
        feed_digits(2);
        check("R9 drop with byte", chk_value, 16'hBB3D);

        // R6 transparent forces CRC
        mode_sel = 2'b11; transparent = 1'b1;
        do_clear(1'b0);
        feed_digits(0);
        check("R6 transparent crc", chk_value, 16'hBB3D);
        transparent = 1'b0;

        // R7 reserved modes
        mode_sel = 2'b00;
        do_clear(1'b0);
        feed_digits(0);
        check("R7 mode 00", chk_value, 16'hBB3D);
        mode_sel = 2'b10;
        do_clear(1'b0);
        feed_digits(0);
        check("R7 mode 10", chk_value, 16'hBB3D);

        // R10 idle holds
        repeat (5) @(negedge clk);
        check("R10 idle hold", chk_value, 16'hBB3D);

        // R2 clear priority over byte and drop, and loads held copy
        @(negedge clk);
        clear = 1'b1; preset_ones = 1'b1; byte_valid = 1'b1; byte_data = 8'h55; drop_last = 1'b1;
        @(negedge clk);
        clear = 1'b0; byte_valid = 1'b0; drop_last = 1'b0; byte_data = 8'h00;
        // R11 visible one edge later
        check("R2 clear priority", chk_value, 16'hFFFF);
        step(1'b0, 1'b1, 8'h00);
        check("R2 held preset", chk_value, 16'hFFFF);

        // R1 reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset midstream", chk_value, 16'h0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule